// File: doc/BRIEF.md
# Sector Erase Queue Controller

This block gathers sector erase requests into a pending set, holds them in a retriggerable acceptance window measured in microsecond ticks, and then works through the set one sector at a time. Each sector takes a programmable number of ticks to erase. The erase can be put on hold and continued later. A hold requested while the window is still open takes effect at once. A hold requested during the erase itself takes effect after a programmable number of ticks. A hardware abort drops everything and returns the block to idle.

The inputs are single-cycle command strobes that have already been decoded: sector erase with a sector number, whole-array erase, suspend, resume, any other command, and abort. A one-cycle tick pulse marks each microsecond. A protection mask keeps protected sectors out of the erase set.

The outputs are the set of sectors still to be erased, a busy flag, a status bit that shows the acceptance window is over, a suspended flag, and a one-cycle completion pulse.

Top module: `erase_queue_ctrl`

## Requirements
- R1: After reset, `busy`, `window_closed`, `suspended` and `done` are 0 and `erase_mask` is all zeros. Whenever `busy` is 0, the mask is empty.
- R2: When idle, a sector erase command with `sector_idx` below NUM_SECTORS sets bit `sector_idx` of `erase_mask`, raises `busy` and opens the window (`window_closed`=0). A command with an index of NUM_SECTORS or more is ignored.
- R3: Each valid sector erase command received while the window is open adds its bit and restarts the window. The window closes on exactly the WINDOW_TICKS-th tick after the last such command.
- R4: When the window closes, `window_closed` goes to 1 and erasing starts. Sectors are erased in ascending index order. Each sector takes ERASE_TICKS ticks, and its bit clears on its last tick. No bit is added after the window has closed.
- R5: While the window is open, a whole-array erase, resume or other command empties the set and returns the block to idle without a `done` pulse.
- R6: A suspend while the window is open sets `suspended` and `window_closed` on the next cycle and keeps the set.
- R7: A suspend during an erase sets `suspended` on exactly the SUSPEND_TICKS-th following tick. The erase keeps advancing until then.
- R8: While suspended, ticks and every command except resume and abort have no effect on the set or the progress of the erase. Resume continues the erase where it stopped. A second resume is ignored. A later suspend is accepted again.
- R9: While erasing, sector erase, whole-array erase, resume and other commands are ignored and do not change the set or the timing.
- R10: Abort, in any state, returns the block to idle with an empty set on the next cycle and gives no `done` pulse.
- R11: When idle, a whole-array erase marks every unprotected sector and starts erasing with no window (`window_closed`=1 on the next cycle). Suspend is ignored during a whole-array erase.
- R12: A sector whose `prot_mask` bit is 1 is never added to the set. If the set is empty when erasing starts, `done` pulses on the following cycle and nothing is erased.
- R13: `done` is high for exactly one cycle. That cycle is the first one in which the set is empty after an erase, and `busy` is already 0 in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_erase_req | input | 1 | Sector erase command strobe |
| sector_idx | input | IDX_W (5) | Sector number for the sector erase command |
| chip_erase_req | input | 1 | Whole-array erase command strobe |
| suspend_req | input | 1 | Suspend command strobe |
| resume_req | input | 1 | Resume command strobe |
| other_req | input | 1 | Any other command strobe |
| abort_req | input | 1 | Hardware abort strobe |
| tick_us | input | 1 | One-cycle microsecond tick |
| prot_mask | input | NUM_SECTORS | 1 marks a protected sector |
| erase_mask | output | NUM_SECTORS | Sectors still to be erased |
| busy | output | 1 | An operation is in progress |
| window_closed | output | 1 | The acceptance window is over |
| suspended | output | 1 | The erase is on hold |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output comes from a register. A command therefore shows on the outputs in the cycle right after the edge that samples it, and a tick-driven event shows right after the edge of the tick that completes its count. That tick is the WINDOW_TICKS-th after the last sector command, the ERASE_TICKS-th of a sector, or the SUSPEND_TICKS-th after a suspend. The bench drives each strobe for one cycle starting just after an edge. It samples 1 ns after the next edge. It counts the ticks it issues itself, so it checks each value one tick before its due edge (unchanged) and again right at that edge (changed). The `done` pulse arrives on the cycle after an empty set enters the erase phase, so it is checked there and again one cycle later to confirm it has fallen.

// File: rtl/eq_pkg.sv
package eq_pkg;

    localparam int unsigned DEF_SECTORS       = 19;
    localparam int unsigned DEF_WINDOW_TICKS  = 50;
    localparam int unsigned DEF_SUSPEND_TICKS = 20;
    localparam int unsigned DEF_ERASE_TICKS   = 1000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSP_WAIT,
        ST_SUSPENDED
    } eq_state_e;

    // Strobes from the sequencer to the set register and the counters.
    typedef struct packed {
        logic set_add;
        logic set_clr;
        logic set_fill;
        logic set_retire;
        logic win_load;
        logic win_step;
        logic ers_load;
        logic ers_step;
        logic sus_load;
        logic sus_step;
    } eq_ctl_t;

    function automatic logic past_window(eq_state_e s);
        return (s == ST_ERASE) || (s == ST_SUSP_WAIT) || (s == ST_SUSPENDED);
    endfunction

    function automatic int unsigned count_width(int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/eq_tick_counter.sv
module eq_tick_counter #(
    parameter int unsigned RELOAD = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic expire
);
    localparam int unsigned CW = eq_pkg::count_width(RELOAD);

    logic [CW-1:0] cnt;

    // Expires on the tick that consumes the last remaining count.
    assign expire = step && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(RELOAD);
        end else if (step && (cnt != '0)) begin
            cnt <= expire ? CW'(RELOAD) : (cnt - CW'(1));
        end
    end
endmodule

// File: rtl/eq_sector_set.sv
module eq_sector_set #(
    parameter int unsigned NUM_SECTORS = 19,
    parameter int unsigned IDX_W       = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   fill,
    input  logic                   add,
    input  logic                   retire,
    input  logic [IDX_W-1:0]       idx,
    input  logic [NUM_SECTORS-1:0] prot,
    output logic [NUM_SECTORS-1:0] mask,
    output logic                   empty,
    output logic                   single
);
    logic [NUM_SECTORS-1:0] sel_bit;
    logic [NUM_SECTORS-1:0] drop_low;

    assign sel_bit  = {{(NUM_SECTORS-1){1'b0}}, 1'b1} << idx;
    // Clearing the lowest set bit gives the ascending erase order.
    assign drop_low = mask & (mask - {{(NUM_SECTORS-1){1'b0}}, 1'b1});
    assign empty    = (mask == '0);
    assign single   = !empty && (drop_low == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask <= '0;
        end else if (fill) begin
            mask <= ~prot;
        end else if (add) begin
            mask <= mask | (sel_bit & ~prot);
        end else if (retire) begin
            mask <= drop_low;
        end
    end
endmodule

// File: rtl/eq_sequencer.sv
module eq_sequencer
    import eq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_req,
    input  logic      idx_ok,
    input  logic      chip_req,
    input  logic      susp_req,
    input  logic      res_req,
    input  logic      oth_req,
    input  logic      abort_req,
    input  logic      tick,
    input  logic      win_expire,
    input  logic      ers_expire,
    input  logic      sus_expire,
    input  logic      set_empty,
    input  logic      set_single,
    output eq_ctl_t   ctl,
    output eq_state_e state,
    output logic      done
);
    eq_state_e st_q, st_n;
    logic      chip_q, chip_n;
    logic      done_n;
    logic      finishing;

    // The last sector ends on this tick.
    assign finishing = ers_expire && set_single;

    always_comb begin
        ctl    = '0;
        st_n   = st_q;
        chip_n = chip_q;
        done_n = 1'b0;
        if (abort_req) begin
            ctl.set_clr = 1'b1;
            st_n        = ST_IDLE;
            chip_n      = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (sec_req && idx_ok) begin
                        ctl.set_add  = 1'b1;
                        ctl.win_load = 1'b1;
                        st_n         = ST_WINDOW;
                    end else if (chip_req) begin
                        ctl.set_fill = 1'b1;
                        ctl.ers_load = 1'b1;
                        chip_n       = 1'b1;
                        st_n         = ST_ERASE;
                    end
                end
                ST_WINDOW: begin
                    if (sec_req) begin
                        if (idx_ok) begin
                            ctl.set_add  = 1'b1;
                            ctl.win_load = 1'b1;
                        end
                    end else if (susp_req) begin
                        ctl.ers_load = 1'b1;
                        st_n         = ST_SUSPENDED;
                    end else if (chip_req || res_req || oth_req) begin
                        ctl.set_clr = 1'b1;
                        st_n        = ST_IDLE;
                    end else begin
                        ctl.win_step = tick;
                        if (win_expire) begin
                            ctl.ers_load = 1'b1;
                            st_n         = ST_ERASE;
                        end
                    end
                end
                ST_ERASE: begin
                    if (set_empty) begin
                        done_n = 1'b1;
                        chip_n = 1'b0;
                        st_n   = ST_IDLE;
                    end else begin
                        ctl.ers_step   = tick;
                        ctl.set_retire = ers_expire;
                        if (finishing) begin
                            done_n = 1'b1;
                            chip_n = 1'b0;
                            st_n   = ST_IDLE;
                        end else if (susp_req && !chip_q) begin
                            ctl.sus_load = 1'b1;
                            st_n         = ST_SUSP_WAIT;
                        end
                    end
                end
                ST_SUSP_WAIT: begin
                    ctl.ers_step   = tick;
                    ctl.sus_step   = tick;
                    ctl.set_retire = ers_expire;
                    if (finishing) begin
                        done_n = 1'b1;
                        chip_n = 1'b0;
                        st_n   = ST_IDLE;
                    end else if (sus_expire) begin
                        st_n = ST_SUSPENDED;
                    end
                end
                ST_SUSPENDED: begin
                    if (res_req) begin
                        st_n = ST_ERASE;
                    end
                end
                default: begin
                    ctl.set_clr = 1'b1;
                    st_n        = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            chip_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            st_q   <= st_n;
            chip_q <= chip_n;
            done   <= done_n;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/erase_queue_ctrl.sv
module erase_queue_ctrl
    import eq_pkg::*;
#(
    parameter int unsigned NUM_SECTORS   = DEF_SECTORS,
    parameter int unsigned WINDOW_TICKS  = DEF_WINDOW_TICKS,
    parameter int unsigned SUSPEND_TICKS = DEF_SUSPEND_TICKS,
    parameter int unsigned ERASE_TICKS   = DEF_ERASE_TICKS,
    parameter int unsigned IDX_W         = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sector_erase_req,
    input  logic [IDX_W-1:0]       sector_idx,
    input  logic                   chip_erase_req,
    input  logic                   suspend_req,
    input  logic                   resume_req,
    input  logic                   other_req,
    input  logic                   abort_req,
    input  logic                   tick_us,
    input  logic [NUM_SECTORS-1:0] prot_mask,
    output logic [NUM_SECTORS-1:0] erase_mask,
    output logic                   busy,
    output logic                   window_closed,
    output logic                   suspended,
    output logic                   done
);
    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W + 1)'(NUM_SECTORS);

    eq_ctl_t   ctl;
    eq_state_e state;
    logic      idx_ok;
    logic      win_expire, ers_expire, sus_expire;
    logic      set_empty, set_single;

    assign idx_ok = ({1'b0, sector_idx} < IDX_LIMIT);

    eq_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .sec_req    (sector_erase_req),
        .idx_ok     (idx_ok),
        .chip_req   (chip_erase_req),
        .susp_req   (suspend_req),
        .res_req    (resume_req),
        .oth_req    (other_req),
        .abort_req  (abort_req),
        .tick       (tick_us),
        .win_expire (win_expire),
        .ers_expire (ers_expire),
        .sus_expire (sus_expire),
        .set_empty  (set_empty),
        .set_single (set_single),
        .ctl        (ctl),
        .state      (state),
        .done       (done)
    );

    eq_sector_set #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_set (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl.set_clr),
        .fill   (ctl.set_fill),
        .add    (ctl.set_add),
        .retire (ctl.set_retire),
        .idx    (sector_idx),
        .prot   (prot_mask),
        .mask   (erase_mask),
        .empty  (set_empty),
        .single (set_single)
    );

    eq_tick_counter #(.RELOAD(WINDOW_TICKS)) u_win_cnt (
        .clk(clk), .rst(rst), .load(ctl.win_load), .step(ctl.win_step), .expire(win_expire)
    );

    eq_tick_counter #(.RELOAD(ERASE_TICKS)) u_ers_cnt (
        .clk(clk), .rst(rst), .load(ctl.ers_load), .step(ctl.ers_step), .expire(ers_expire)
    );

    eq_tick_counter #(.RELOAD(SUSPEND_TICKS)) u_sus_cnt (
        .clk(clk), .rst(rst), .load(ctl.sus_load), .step(ctl.sus_step), .expire(sus_expire)
    );

    assign busy          = (state != ST_IDLE);
    assign window_closed = past_window(state);
    assign suspended     = (state == ST_SUSPENDED);
endmodule

// File: rtl/eq_checker.sv
module eq_checker #(
    parameter int unsigned N = 19
) (
    input logic         clk,
    input logic         rst,
    input logic         sector_erase_req,
    input logic         suspend_req,
    input logic         resume_req,
    input logic         abort_req,
    input logic [N-1:0] prot_mask,
    input logic [N-1:0] erase_mask,
    input logic         busy,
    input logic         window_closed,
    input logic         suspended,
    input logic         done
);
    a_r1_idle_empty: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (erase_mask == '0) && !window_closed && !suspended);

    a_r13_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && (erase_mask == '0));

    a_r13_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> !busy && !done && (erase_mask == '0));

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (suspended && !resume_req && !abort_req) |=> suspended && $stable(erase_mask));

    a_r4_no_growth: assert property (@(posedge clk) disable iff (rst)
        (busy && window_closed) |=> ((erase_mask & ~$past(erase_mask)) == '0));

    a_r6_window_suspend: assert property (@(posedge clk) disable iff (rst)
        (busy && !window_closed && suspend_req && !sector_erase_req && !abort_req)
        |=> suspended && window_closed);

    a_r12_prot_excluded: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((erase_mask & ~$past(erase_mask) & $past(prot_mask)) == '0));
endmodule

bind erase_queue_ctrl eq_checker #(.N(NUM_SECTORS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .sector_erase_req (sector_erase_req),
    .suspend_req      (suspend_req),
    .resume_req       (resume_req),
    .abort_req        (abort_req),
    .prot_mask        (prot_mask),
    .erase_mask       (erase_mask),
    .busy             (busy),
    .window_closed    (window_closed),
    .suspended        (suspended),
    .done             (done)
);

// File: tb/erase_queue_ctrl_tb.sv
`timescale 1ns/1ps
module erase_queue_ctrl_tb;
    localparam int unsigned N  = 19;
    localparam int unsigned IW = 5;
    localparam int unsigned WT = 5;
    localparam int unsigned ET = 8;
    localparam int unsigned ST = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          sec_req, chip_req, susp_req, res_req, oth_req, abort_req, tick;
    logic [IW-1:0] idx;
    logic [N-1:0]  prot;
    logic [N-1:0]  mask;
    logic          busy, wclosed, susp, done;

    int tests  = 0;
    int fails  = 0;
    bit closed = 1'b0;

    always #5 clk = ~clk;

    erase_queue_ctrl #(
        .NUM_SECTORS(N), .WINDOW_TICKS(WT), .SUSPEND_TICKS(ST), .ERASE_TICKS(ET)
    ) u_dut (
        .clk(clk), .rst(rst), .sector_erase_req(sec_req), .sector_idx(idx),
        .chip_erase_req(chip_req), .suspend_req(susp_req), .resume_req(res_req),
        .other_req(oth_req), .abort_req(abort_req), .tick_us(tick), .prot_mask(prot),
        .erase_mask(mask), .busy(busy), .window_closed(wclosed), .suspended(susp), .done(done)
    );

    function automatic logic [N-1:0] bm(int i);
        return {{(N-1){1'b0}}, 1'b1} << i;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic state_is(string tag, logic b, logic w, logic s, logic [N-1:0] m);
        chk({tag, " busy"}, 32'(busy), 32'(b));
        chk({tag, " window_closed"}, 32'(wclosed), 32'(w));
        chk({tag, " suspended"}, 32'(susp), 32'(s));
        chk({tag, " mask"}, 32'(mask), 32'(m));
    endtask

    // Each task starts and ends 1 ns after a rising edge.
    task automatic cycle();
        @(posedge clk); #1;
    endtask

    task automatic sec(int i);
        idx = IW'(i); sec_req = 1'b1; cycle(); sec_req = 1'b0;
    endtask
    task automatic chip();  chip_req  = 1'b1; cycle(); chip_req  = 1'b0; endtask
    task automatic spnd();  susp_req  = 1'b1; cycle(); susp_req  = 1'b0; endtask
    task automatic rsm();   res_req   = 1'b1; cycle(); res_req   = 1'b0; endtask
    task automatic oth();   oth_req   = 1'b1; cycle(); oth_req   = 1'b0; endtask
    task automatic abrt();  abort_req = 1'b1; cycle(); abort_req = 1'b0; endtask
    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1; cycle(); tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        state_is("R1 reset", 1'b0, 1'b0, 1'b0, '0);
        chk("R1 reset done", 32'(done), 0);
    endtask

    task automatic t_window_and_order();
        sec(25);
        state_is("R2 bad index ignored", 1'b0, 1'b0, 1'b0, '0);
        sec(5);
        state_is("R2 open", 1'b1, 1'b0, 1'b0, bm(5));
        ticks(3);
        sec(2);
        state_is("R3 add", 1'b1, 1'b0, 1'b0, bm(5) | bm(2));
        ticks(WT - 1);
        chk("R3 restarted window", 32'(wclosed), 0);
        ticks(1);
        state_is("R4 closed", 1'b1, 1'b1, 1'b0, bm(5) | bm(2));
        ticks(ET - 1);
        chk("R4 first sector pending", 32'(mask), 32'(bm(5) | bm(2)));
        ticks(1);
        chk("R4 lowest first", 32'(mask), 32'(bm(5)));
        ticks(ET - 1);
        chk("R13 no early done", 32'(done), 0);
        ticks(1);
        chk("R13 done", 32'(done), 1);
        state_is("R13 idle at done", 1'b0, 1'b0, 1'b0, '0);
        cycle();
        chk("R13 done one cycle", 32'(done), 0);
    endtask

    task automatic t_window_discard();
        sec(7); oth();
        state_is("R5 other", 1'b0, 1'b0, 1'b0, '0);
        sec(7); chip();
        state_is("R5 chip", 1'b0, 1'b0, 1'b0, '0);
        sec(7); rsm();
        state_is("R5 resume", 1'b0, 1'b0, 1'b0, '0);
        chk("R5 no done", 32'(done), 0);
    endtask

    task automatic t_suspend_window();
        sec(1); ticks(2); spnd();
        state_is("R6 suspend in window", 1'b1, 1'b1, 1'b1, bm(1));
        ticks(10);
        state_is("R8 ticks ignored", 1'b1, 1'b1, 1'b1, bm(1));
        rsm();
        chk("R8 resumed", 32'(susp), 0);
        ticks(ET - 1);
        chk("R8 erase after window suspend", 32'(mask), 32'(bm(1)));
        ticks(1);
        chk("R8 done after resume", 32'(done), 1);
        cycle();
    endtask

    task automatic t_suspend_erase();
        sec(3); sec(4); ticks(WT); ticks(2);
        spnd();
        chk("R7 not immediate", 32'(susp), 0);
        ticks(ST - 1);
        chk("R7 before latency", 32'(susp), 0);
        ticks(1);
        state_is("R7 suspended", 1'b1, 1'b1, 1'b1, bm(3) | bm(4));
        ticks(10); oth(); sec(9); chip(); spnd();
        state_is("R8 frozen", 1'b1, 1'b1, 1'b1, bm(3) | bm(4));
        rsm();
        chk("R8 resume", 32'(susp), 0);
        rsm();
        state_is("R8 second resume ignored", 1'b1, 1'b1, 1'b0, bm(3) | bm(4));
        ticks(ET - 2 - ST - 1);
        chk("R8 progress kept", 32'(mask), 32'(bm(3) | bm(4)));
        ticks(1);
        chk("R8 progress kept end", 32'(mask), 32'(bm(4)));
        spnd(); ticks(ST);
        state_is("R8 new suspend", 1'b1, 1'b1, 1'b1, bm(4));
        rsm();
        ticks(ET - ST - 1);
        chk("R8 last sector pending", 32'(mask), 32'(bm(4)));
        ticks(1);
        chk("R8 done", 32'(done), 1);
        cycle();
    endtask

    task automatic t_erase_ignores();
        sec(0); ticks(WT);
        sec(6); chip(); oth(); rsm();
        state_is("R9 ignored", 1'b1, 1'b1, 1'b0, bm(0));
        ticks(ET - 1);
        chk("R9 timing kept", 32'(done), 0);
        ticks(1);
        chk("R9 done on time", 32'(done), 1);
        cycle();
    endtask

    task automatic t_abort();
        sec(8); abrt();
        state_is("R10 abort window", 1'b0, 1'b0, 1'b0, '0);
        sec(8); ticks(WT + 3); abrt();
        state_is("R10 abort erase", 1'b0, 1'b0, 1'b0, '0);
        chk("R10 no done", 32'(done), 0);
        sec(8); spnd(); abrt();
        state_is("R10 abort suspended", 1'b0, 1'b0, 1'b0, '0);
        cycle();
        chk("R10 no done later", 32'(done), 0);
    endtask

    task automatic t_chip();
        prot = ~(bm(17) | bm(18));
        chip();
        state_is("R11 chip no window", 1'b1, 1'b1, 1'b0, bm(17) | bm(18));
        spnd(); ticks(ST);
        chk("R11 suspend ignored", 32'(susp), 0);
        ticks(ET - ST - 1);
        chk("R11 first pending", 32'(mask), 32'(bm(17) | bm(18)));
        ticks(1);
        chk("R11 first done", 32'(mask), 32'(bm(18)));
        ticks(ET);
        chk("R11 done", 32'(done), 1);
        cycle();
    endtask

    task automatic t_protect();
        prot = bm(4);
        sec(4); sec(6);
        chk("R12 protected dropped", 32'(mask), 32'(bm(6)));
        abrt();
        prot = '1;
        sec(4);
        state_is("R12 empty window", 1'b1, 1'b0, 1'b0, '0);
        ticks(WT);
        chk("R12 closed empty", 32'(wclosed), 1);
        chk("R12 done not yet", 32'(done), 0);
        cycle();
        chk("R12 done empty", 32'(done), 1);
        chip();
        state_is("R12 chip all protected", 1'b1, 1'b1, 1'b0, '0);
        cycle();
        chk("R12 chip done", 32'(done), 1);
        prot = '0;
        cycle();
    endtask

    task automatic finish_run();
        if (!closed) begin
            closed = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; sec_req = 0; chip_req = 0; susp_req = 0; res_req = 0;
        oth_req = 0; abort_req = 0; tick = 0; idx = '0; prot = '0;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        t_reset();
        t_window_and_order();
        t_window_discard();
        t_suspend_window();
        t_suspend_erase();
        t_erase_ignores();
        t_abort();
        t_chip();
        t_protect();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule